// File: doc/BRIEF.md
# Triple Configuration Readback Scrubber

This block watches over three redundant logic devices that should hold identical configuration. On each scrub tick it asks all three to stream their configuration back at once and takes one byte from each per beat. A beat is taken only when all three streams offer a byte in the same cycle. Each byte position is compared across the three devices. A device whose byte differs from both of the other two gets a sticky miscompare flag for the rest of the pass. If all three bytes differ from one another, all three devices are flagged.

After the final byte of the pass, the scrubber acts on the flags. With no flags it goes quietly back to idle: it issues no reload request, never enables the nonvolatile image reader and sends no sync request. With one or more flags it clears and reloads the flagged devices only. It does this one device at a time, in ascending index order, and holds each request until that device acknowledges. It then pulses a system sync request so the reloaded devices rejoin in lock-step. A device that received a corrupted image will miscompare again on the next tick and be reloaded again.

Top module: `tmrScrubber`

## Requirements
- R1: After reset the block is idle: `busy`, `rbReady`, `rbStart`, `imgEn`, `syncReq`, `reloadReq` and `missFlags` are all zero.
- R2: A `scrubTick` taken while idle raises `busy` on the next edge and produces exactly one single-cycle `rbStart` pulse for the pass.
- R3: A readback beat is accepted (`rbReady` high) only during the readback phase and only when all three bits of `rbValid` are high. A partial valid pattern consumes no byte.
- R4: Bit d of `missFlags` is set when device d's byte differs from both of the other bytes at the same position. When all three bytes differ pairwise, all three bits are set. Flags stay set for the rest of the pass, including a miscompare on the final byte. They remain readable until the next pass starts.
- R5: A pass with no miscompare returns to idle with no reload request, no `imgEn` and no `syncReq`.
- R6: Flagged devices are reloaded one at a time in ascending index order. `reloadReq` is one-hot (bit d selects device d) and is held steady until the matching `reloadDone` bit arrives. Unflagged devices are never requested.
- R7: A `reloadDone` bit for a device that is not currently requested has no effect.
- R8: After the last reload completes, `syncReq` is high for exactly one cycle and `busy` falls on the following edge.
- R9: `imgEn` is high exactly while a reload request is outstanding, so the image is read only after a miscompare.
- R10: A `scrubTick` arriving while `busy` is high is ignored: no second `rbStart` and no extra pass.
- R11: `busy` stays high from the tick until the return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| scrubTick | input | 1 | Start-of-scrub tick |
| rbData0 | input | BYTE_W | Readback byte, device 0 |
| rbData1 | input | BYTE_W | Readback byte, device 1 |
| rbData2 | input | BYTE_W | Readback byte, device 2 |
| rbValid | input | 3 | Per-device readback byte valid |
| rbReady | output | 1 | Beat accepted from all three streams |
| rbStart | output | 1 | One-cycle request to begin readback |
| missFlags | output | 3 | Sticky per-device miscompare flags |
| reloadReq | output | 3 | One-hot clear/reload request |
| reloadDone | input | 3 | Per-device reload acknowledge |
| imgEn | output | 1 | Nonvolatile image read enable |
| syncReq | output | 1 | One-cycle system sync request |
| busy | output | 1 | Pass in progress |

## Verification
The bench builds the block with FRAME_BYTES = 8 and BYTE_W = 8. Short frames allow several dozen complete passes, so faults can land on the first, middle and final byte. They also cover every count of flagged devices from none to three, including the case where all three bytes differ pairwise. The short frames also leave room for irregular valid gaps and for ticks and stray acknowledges injected while a pass is running. The 8-bit bytes keep the pairwise-distinct corruption patterns simple to build.

// File: rtl/scrubPkg.sv
package scrubPkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_READ, S_DECIDE, S_RELOAD, S_SYNC
  } scrubState_e;

  typedef struct packed {
    logic clearFlags;
    logic readEn;
  } dpStrobe_t;

  function automatic logic [2:0] lowestOne(input logic [2:0] m);
    return m & (~m + 3'd1);
  endfunction
endpackage

// File: rtl/scrubDatapath.sv
module scrubDatapath
  import scrubPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAME_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] rbData0,
  input  logic [BYTE_W-1:0] rbData1,
  input  logic [BYTE_W-1:0] rbData2,
  input  logic [2:0]        rbValid,
  output logic              rbReady,
  output logic              lastBeat,
  output logic [2:0]        missFlags
);
  localparam int CNT_W = (FRAME_BYTES > 2) ? $clog2(FRAME_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  logic [BYTE_W-1:0] laneByte [3];
  logic [2:0]        byteMiss;
  logic [CNT_W-1:0]  beatCnt;
  logic              accept;

  assign laneByte[0] = rbData0;
  assign laneByte[1] = rbData1;
  assign laneByte[2] = rbData2;

  assign accept   = strobe.readEn && (&rbValid);
  assign rbReady  = accept;
  assign lastBeat = accept && (beatCnt == LAST_IDX);

  for (genvar d = 0; d < 3; d++) begin : gLane
    localparam int P = (d + 1) % 3;
    localparam int Q = (d + 2) % 3;
    assign byteMiss[d] = (laneByte[d] != laneByte[P]) && (laneByte[d] != laneByte[Q]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missFlags <= '0;
      beatCnt   <= '0;
    end else if (strobe.clearFlags) begin
      missFlags <= '0;
      beatCnt   <= '0;
    end else if (accept) begin
      missFlags <= missFlags | byteMiss;
      beatCnt   <= (beatCnt == LAST_IDX) ? '0 : beatCnt + 1'b1;
    end
  end

  // R4: flags only accumulate within a pass
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearFlags |=> ((missFlags & $past(missFlags)) == $past(missFlags)));

  // R3: no byte taken means flags do not move
  a_r3_no_accept_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!rbReady && !strobe.clearFlags) |=> $stable(missFlags));
endmodule

// File: rtl/scrubControl.sv
module scrubControl
  import scrubPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       scrubTick,
  input  logic       lastBeat,
  input  logic [2:0] missFlags,
  input  logic [2:0] reloadDone,
  output dpStrobe_t  strobe,
  output logic       rbStart,
  output logic [2:0] reloadReq,
  output logic       imgEn,
  output logic       syncReq,
  output logic       busy
);
  scrubState_e state, nextState;
  logic [2:0]  pending, nextPending;
  logic        doneHit;

  assign reloadReq = (state == S_RELOAD) ? lowestOne(pending) : 3'b000;
  assign doneHit   = |(reloadDone & reloadReq);

  always_comb begin
    nextState   = state;
    nextPending = pending;
    unique case (state)
      S_IDLE:   if (scrubTick) nextState = S_START;
      S_START:  nextState = S_READ;
      S_READ:   if (lastBeat) nextState = S_DECIDE;
      S_DECIDE: begin
        nextPending = missFlags;
        nextState   = (missFlags == 3'b000) ? S_IDLE : S_RELOAD;
      end
      S_RELOAD: if (doneHit) begin
        nextPending = pending & ~reloadReq;
        if ((pending & ~reloadReq) == 3'b000) nextState = S_SYNC;
      end
      S_SYNC:   nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      pending <= '0;
    end else begin
      state   <= nextState;
      pending <= nextPending;
    end
  end

  assign strobe.clearFlags = (state == S_START);
  assign strobe.readEn     = (state == S_READ);
  assign rbStart           = (state == S_START);
  assign imgEn             = (state == S_RELOAD);
  assign syncReq           = (state == S_SYNC);
  assign busy              = (state != S_IDLE);

  // R6: one device at a time
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reloadReq));

  // R6: request held until its own acknowledge (R7: others ignored)
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((reloadReq != 3'b000) && ((reloadDone & reloadReq) == 3'b000)) |=> (reloadReq == $past(reloadReq)));

  // R9: image read only while a reload is requested
  a_r9_img_reload: assert property (@(posedge clk) disable iff (!rstN)
    imgEn == (reloadReq != 3'b000));

  // R8: sync is a single-cycle pulse ending the pass
  a_r8_sync_pulse: assert property (@(posedge clk) disable iff (!rstN)
    syncReq |=> (!syncReq && !busy));

  // R2: tick from idle starts a pass
  a_r2_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && scrubTick) |=> (busy && rbStart));

  // R10: tick while busy never restarts the readback request
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rbStart) |=> !rbStart);
endmodule

// File: rtl/tmrScrubber.sv
module tmrScrubber
  import scrubPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int FRAME_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scrubTick,
  input  logic [BYTE_W-1:0] rbData0,
  input  logic [BYTE_W-1:0] rbData1,
  input  logic [BYTE_W-1:0] rbData2,
  input  logic [2:0]        rbValid,
  output logic              rbReady,
  output logic              rbStart,
  output logic [2:0]        missFlags,
  output logic [2:0]        reloadReq,
  input  logic [2:0]        reloadDone,
  output logic              imgEn,
  output logic              syncReq,
  output logic              busy
);
  dpStrobe_t strobe;
  logic      lastBeat;

  scrubDatapath #(.BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rbData0(rbData0), .rbData1(rbData1), .rbData2(rbData2),
    .rbValid(rbValid), .rbReady(rbReady), .lastBeat(lastBeat),
    .missFlags(missFlags)
  );

  scrubControl uCtl (
    .clk(clk), .rstN(rstN), .scrubTick(scrubTick), .lastBeat(lastBeat),
    .missFlags(missFlags), .reloadDone(reloadDone), .strobe(strobe),
    .rbStart(rbStart), .reloadReq(reloadReq), .imgEn(imgEn),
    .syncReq(syncReq), .busy(busy)
  );
endmodule

// File: tb/tb_tmrScrubber.sv
module tb_tmrScrubber;
  localparam int FB = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scrubTick = 1'b0;
  logic [7:0] rbData0 = '0, rbData1 = '0, rbData2 = '0;
  logic [2:0] rbValid = '0;
  logic [2:0] reloadDone = '0;
  logic       rbReady, rbStart, imgEn, syncReq, busy;
  logic [2:0] missFlags, reloadReq;

  tmrScrubber #(.BYTE_W(8), .FRAME_BYTES(FB)) dut (
    .clk(clk), .rstN(rstN), .scrubTick(scrubTick),
    .rbData0(rbData0), .rbData1(rbData1), .rbData2(rbData2),
    .rbValid(rbValid), .rbReady(rbReady), .rbStart(rbStart),
    .missFlags(missFlags), .reloadReq(reloadReq), .reloadDone(reloadDone),
    .imgEn(imgEn), .syncReq(syncReq), .busy(busy)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int startCnt = 0, syncCnt = 0;
  logic [7:0] fd [3][FB];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rbStart) startCnt <= startCnt + 1;
    if (syncReq) syncCnt <= syncCnt + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expFlags();
    logic [2:0] f = '0;
    for (int b = 0; b < FB; b++)
      for (int d = 0; d < 3; d++)
        if (fd[d][b] != fd[(d+1)%3][b] && fd[d][b] != fd[(d+2)%3][b]) f[d] = 1'b1;
    return f;
  endfunction

  function automatic logic [7:0] nz();
    return 8'(1 + ($urandom % 255));
  endfunction

  task automatic baseFrame();
    for (int b = 0; b < FB; b++) begin
      logic [7:0] v = 8'($urandom);
      for (int d = 0; d < 3; d++) fd[d][b] = v;
    end
  endtask

  task automatic randFrame(input int mode);
    baseFrame();
    case (mode)
      1: begin
        int d = $urandom % 3;
        fd[d][$urandom % FB] ^= nz();
      end
      2: begin
        int d = $urandom % 3;
        fd[d][$urandom % FB] ^= nz();
        fd[(d+1)%3][$urandom % FB] ^= nz();
      end
      3: for (int b = 0; b < FB; b++)
           for (int d = 0; d < 3; d++) fd[d][b] = 8'($urandom % 4);
      4: begin
        int b = $urandom % FB;
        fd[1][b] = fd[0][b] ^ 8'h0F;
        fd[2][b] = fd[0][b] ^ 8'hF0;
      end
      default: ;
    endcase
  endtask

  task automatic runPass(input bit injectTick, input bit strayDone);
    logic [2:0] exp = expFlags();
    logic [2:0] remain = exp;
    int k = 0;
    int guard = 0;
    startCnt = 0;
    syncCnt = 0;
    @(negedge clk); scrubTick = 1'b1;
    @(negedge clk); scrubTick = 1'b0;
    chk(busy == 1'b1, "R11 busy after tick", busy, 1);
    chk(rbStart == 1'b1, "R2 rbStart pulse", rbStart, 1);
    while (k < FB) begin
      @(negedge clk);
      scrubTick = injectTick && (k == FB/2);
      rbData0 = fd[0][k]; rbData1 = fd[1][k]; rbData2 = fd[2][k];
      if ($urandom % 4 == 0) begin
        rbValid = 3'($urandom % 7);
        #1 chk(rbReady == 1'b0, "R3 partial valid not taken", rbReady, 0);
      end else begin
        rbValid = 3'b111;
        #1 if (rbReady) begin
          @(posedge clk);
          k++;
        end
      end
    end
    @(negedge clk); rbValid = 3'b000; scrubTick = 1'b0;
    while (busy && guard < 200) begin
      guard++;
      if (reloadReq != 3'b000) begin
        logic [2:0] want = remain & (~remain + 3'd1);
        logic [2:0] held = reloadReq;
        chk(reloadReq == want, "R6 order", reloadReq, want);
        chk(imgEn == 1'b1, "R9 imgEn during reload", imgEn, 1);
        for (int w = 0; w < int'($urandom % 3); w++) begin
          @(negedge clk);
          chk(reloadReq == held, "R6 held", reloadReq, held);
        end
        if (strayDone) begin
          reloadDone = ~held;
          @(negedge clk); reloadDone = 3'b000;
          chk(reloadReq == held, "R7 stray done ignored", reloadReq, held);
        end
        reloadDone = held;
        @(negedge clk); reloadDone = 3'b000;
        remain = remain & ~held;
      end else begin
        chk(imgEn == 1'b0, "R9 no imgEn without reload", imgEn, 0);
        @(negedge clk);
      end
    end
    chk(remain == 3'b000, "R6 all flagged reloaded", remain, 0);
    chk(missFlags == exp, "R4 flags", missFlags, exp);
    chk(syncCnt == ((exp != 0) ? 1 : 0), (exp != 0) ? "R8 one sync" : "R5 no sync", syncCnt, (exp != 0) ? 1 : 0);
    chk(startCnt == 1, "R10 single start", startCnt, 1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 stays idle", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && rbReady == 0 && rbStart == 0 && imgEn == 0 && syncReq == 0,
        "R1 idle outputs", {busy, rbReady, rbStart, imgEn, syncReq}, 0);
    chk(reloadReq == 0 && missFlags == 0, "R1 zero flags", {reloadReq, missFlags}, 0);

    baseFrame(); runPass(1'b0, 1'b0);                       // R5 clean
    baseFrame(); fd[2][FB-1] ^= 8'h01; runPass(1'b0, 1'b0); // R4 last byte
    baseFrame(); fd[0][0] ^= 8'h80; runPass(1'b1, 1'b1);    // R10 R7
    baseFrame(); fd[0][0] ^= 8'h80; runPass(1'b0, 1'b0);    // repeat scrub
    baseFrame(); fd[1][3] = fd[0][3] ^ 8'h11; fd[2][3] = fd[0][3] ^ 8'h22;
    runPass(1'b0, 1'b1);                                    // R4 all differ
    for (int i = 0; i < 30; i++) begin
      randFrame($urandom % 5);
      runPass(1'($urandom % 2), 1'($urandom % 2));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule